// File: doc/BRIEF.md
# Interrupt Pin Controller with Sticky Event Flags

This block collects three single-cycle event strobes (a watchdog timeout, an alarm match and a power-fail warning) into sticky status flags. It also drives one interrupt line. Each event always records itself in its own flag. An event reaches the line only when its own enable bit in an 8-bit control register is set. Software clears all flags at once by strobing a flags-read input, which models a read of the flags register.

The same control register sets how the line is presented. In push-pull mode the line is active high. In open-drain mode the block only asserts a pull-low enable and relies on an external pull-up. The register also picks the assertion style. In level mode the line stays asserted until the flags are read. In pulse mode the line stays asserted for a fixed number of strobes of a slow tick input. The default of 7 ticks at 32 Hz gives a pulse of roughly 0.22 s.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset the control register reads 0, all three flags are 0, `irq_level` is 0 and `irq_pull_low` is 0.
- R2: A `cfg_we` cycle loads `cfg_wdata` into the control register, which is visible on `cfg_rdata` in the next cycle. Bits 7, 6, 5, 3 and 2 are writable. Bits 4, 1 and 0 always read 0.
- R3: Flag positions are `flags[2]` for the watchdog, `flags[1]` for the alarm and `flags[0]` for power fail. An event strobe sets its flag from the next cycle on, whatever the enables are. A set flag stays set until a flags read.
- R4: A `flags_rd` cycle clears all flags in the next cycle, except a flag whose event strobe arrives in that same cycle; that flag is set.
- R5: An event asserts the line in the next cycle only if its enable bit is 1. The enable bits are bit 7 for the watchdog, bit 6 for the alarm and bit 5 for power fail. A disabled event leaves the line unchanged.
- R6: With bit 3 = 1 an active line shows as `irq_level` = 1 and `irq_pull_low` = 0. With bit 3 = 0 it shows as `irq_pull_low` = 1, and `irq_level` is never 1.
- R7: With bit 2 = 0 (level mode) the line stays asserted until a `flags_rd` cycle, after which it is released in the next cycle. An enabled event in the read cycle keeps it asserted.
- R8: With bit 2 = 1 (pulse mode) the line is released in the cycle after the PULSE_TICKS-th `tick` strobe that follows the triggering event. A tick in the triggering cycle is not counted. `flags_rd` does not shorten the pulse.
- R9: An enabled event during an active pulse restarts the count at PULSE_TICKS.
- R10: A `cfg_we` cycle releases any active assertion in the next cycle. Events in the write cycle set their flags but do not assert the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| flags_rd | input | 1 | Flags read strobe; clears the flags |
| ev_wdog | input | 1 | Watchdog timeout strobe |
| ev_alarm | input | 1 | Alarm match strobe |
| ev_pfail | input | 1 | Power-fail strobe |
| tick | input | 1 | Slow time-base strobe for pulse timing |
| flags | output | 3 | Sticky flags {watchdog, alarm, power fail} |
| irq_level | output | 1 | Push-pull active-high line |
| irq_pull_low | output | 1 | Open-drain pull-low enable |

## Verification
The hardest situations to reach are the coincidences: an event in the same cycle as a flags read, a tick, a restart of a running pulse, or a control write. The directed phases place each of these on an exact cycle. The bench also counts ticks to the boundary cycle where a pulse ends. A long phase of random strobes and random control writes then reaches further overlaps. A behavioural model compares all outputs with the design on every clock.

// File: rtl/irq_pin_pkg.sv
// Package: shared constants and control-register view for the interrupt pin controller.
// Assumes: three event sources in the fixed order {watchdog, alarm, power fail}.
package irq_pin_pkg;
    localparam int SRC_N  = 3;
    localparam int CFG_W  = 8;
    localparam int B_POL  = 3;
    localparam int B_MODE = 2;
    localparam int B_EN_LO = 5;
    localparam logic [CFG_W-1:0] CFG_WR_MASK = 8'hEC;

    typedef enum int unsigned {
        SRC_PFAIL = 0,
        SRC_ALARM = 1,
        SRC_WDOG  = 2
    } src_e;

    typedef struct packed {
        logic [SRC_N-1:0] en;
        logic             pol_high;
        logic             pulse_mode;
    } cfg_t;
endpackage

// File: rtl/irq_cfg_reg.sv
// Module: control register. Stores the writable bits and presents a decoded view.
// Assumes: reserved bits are masked on write, so they always read 0.
module irq_cfg_reg
    import irq_pin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output cfg_t             cfg
);
    logic [CFG_W-1:0] reg_q;

    // Purpose: load masked write data, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= '0;
        else if (we)
            reg_q <= wdata & CFG_WR_MASK;
    end

    // Purpose: decode the stored bits into named fields.
    always_comb begin
        rdata          = reg_q;
        cfg.en         = reg_q[B_EN_LO +: SRC_N];
        cfg.pol_high   = reg_q[B_POL];
        cfg.pulse_mode = reg_q[B_MODE];
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Module: one sticky flag per source. An event sets its flag; a read clears all flags.
// Assumes: an event coinciding with a read takes priority for its own flag.
module irq_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         rd,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic f_q;
        // Purpose: set on event, clear on read, event wins.
        always_ff @(posedge clk) begin
            if (!rst_n)
                f_q <= 1'b0;
            else
                f_q <= ev[i] | (f_q & ~rd);
        end
        assign flags[i] = f_q;
    end
endmodule

// File: rtl/irq_pulse_timer.sv
// Module: pulse-width timer counted in tick strobes.
// Assumes: a load takes priority over a tick in the same cycle; a kill takes priority over both.
module irq_pulse_timer #(
    parameter int PULSE_TICKS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic kill,
    input  logic tick,
    output logic busy
);
    localparam int CNT_W = $clog2(PULSE_TICKS + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_TICKS);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: reload on a trigger, count down on ticks until zero.
    always_ff @(posedge clk) begin
        if (!rst_n || kill)
            cnt_q <= '0;
        else if (load)
            cnt_q <= LOAD_VAL;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/irq_assert_ctrl.sv
// Module: decides whether the interrupt line is active in level or pulse mode.
// Assumes: a mode change only happens through a control write, which releases both state holders.
module irq_assert_ctrl #(
    parameter int PULSE_TICKS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic cfg_wr,
    input  logic flags_rd,
    input  logic tick,
    input  logic pulse_mode,
    output logic active
);
    logic lvl_q;
    logic pulse_busy;

    // Purpose: level-mode hold, set by a trigger and released by a flags read.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_wr)
            lvl_q <= 1'b0;
        else if (fire && !pulse_mode)
            lvl_q <= 1'b1;
        else if (flags_rd)
            lvl_q <= 1'b0;
    end

    irq_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fire && pulse_mode),
        .kill  (cfg_wr),
        .tick  (tick),
        .busy  (pulse_busy)
    );

    // Purpose: select the state holder for the current mode.
    always_comb begin
        active = pulse_mode ? pulse_busy : lvl_q;
    end
endmodule

// File: rtl/irq_pin_ctrl.sv
// Module: top level. Merges three event strobes into sticky flags and one interrupt line
// with selectable polarity (push-pull high or open-drain low) and pulse or level mode.
// Assumes: strobes are synchronous single-cycle pulses; tick is a slow time base.
module irq_pin_ctrl
    import irq_pin_pkg::*;
#(
    parameter int PULSE_TICKS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             flags_rd,
    input  logic             ev_wdog,
    input  logic             ev_alarm,
    input  logic             ev_pfail,
    input  logic             tick,
    output logic [SRC_N-1:0] flags,
    output logic             irq_level,
    output logic             irq_pull_low
);
    cfg_t             cfg;
    logic [SRC_N-1:0] ev_vec;
    logic             fire;
    logic             active;

    irq_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    // Purpose: gather the strobes and gate them with their enables; a write blocks triggers.
    always_comb begin
        ev_vec = '0;
        ev_vec[SRC_WDOG]  = ev_wdog;
        ev_vec[SRC_ALARM] = ev_alarm;
        ev_vec[SRC_PFAIL] = ev_pfail;
        fire = |(ev_vec & cfg.en) && !cfg_we;
    end

    irq_flag_bank #(.N(SRC_N)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev_vec),
        .rd    (flags_rd),
        .flags (flags)
    );

    irq_assert_ctrl #(.PULSE_TICKS(PULSE_TICKS)) u_assert (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .cfg_wr     (cfg_we),
        .flags_rd   (flags_rd),
        .tick       (tick),
        .pulse_mode (cfg.pulse_mode),
        .active     (active)
    );

    // Purpose: present the line per polarity; open-drain never drives high.
    always_comb begin
        irq_level    = active &  cfg.pol_high;
        irq_pull_low = active & ~cfg.pol_high;
    end
endmodule

// File: rtl/irq_pin_ctrl_chk.sv
// Module: assertion checker bound to irq_pin_ctrl; observes ports only.
module irq_pin_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [7:0] cfg_rdata,
    input logic       flags_rd,
    input logic       ev_wdog,
    input logic       ev_alarm,
    input logic       ev_pfail,
    input logic       tick,
    input logic [2:0] flags,
    input logic       irq_level,
    input logic       irq_pull_low
);
    logic [2:0] ev_v;
    logic       act;
    assign ev_v = {ev_wdog, ev_alarm, ev_pfail};
    assign act  = irq_level | irq_pull_low;

    p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[4] == 1'b0 && cfg_rdata[1] == 1'b0 && cfg_rdata[0] == 1'b0);

    p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_v != 3'b000) |=> ((flags & $past(ev_v)) == $past(ev_v)));

    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_rd |=> ((flags & $past(flags)) == $past(flags)));

    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd && ev_v == 3'b000) |=> (flags == 3'b000));

    p_no_unarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !cfg_we && (ev_v & cfg_rdata[7:5]) == 3'b000) |=> !act);

    p_one_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_level && irq_pull_low));

    p_od_low_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[3] |-> !irq_level);

    p_level_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !cfg_rdata[2] && !flags_rd && !cfg_we) |=> act);

    p_pulse_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act && cfg_rdata[2] && !tick && !cfg_we) |=> act);

    p_write_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !act);
endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_rdata    (cfg_rdata),
    .flags_rd     (flags_rd),
    .ev_wdog      (ev_wdog),
    .ev_alarm     (ev_alarm),
    .ev_pfail     (ev_pfail),
    .tick         (tick),
    .flags        (flags),
    .irq_level    (irq_level),
    .irq_pull_low (irq_pull_low)
);

// File: tb/sim_irq_pin_ctrl.sv
module sim_irq_pin_ctrl;
    localparam int PT = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       flags_rd = 1'b0;
    logic       ev_wdog = 1'b0;
    logic       ev_alarm = 1'b0;
    logic       ev_pfail = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] flags;
    logic       irq_level;
    logic       irq_pull_low;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // reference model state
    int m_cfg = 0;
    int m_flags = 0;
    int m_lvl = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    irq_pin_ctrl #(.PULSE_TICKS(PT)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .flags_rd(flags_rd), .ev_wdog(ev_wdog),
        .ev_alarm(ev_alarm), .ev_pfail(ev_pfail), .tick(tick), .flags(flags),
        .irq_level(irq_level), .irq_pull_low(irq_pull_low)
    );

    // behavioural model updated on each rising edge from the applied inputs
    always @(posedge clk) begin
        int evs;
        int en;
        bit trig;
        if (!rst_n) begin
            m_cfg = 0; m_flags = 0; m_lvl = 0; m_cnt = 0;
        end else begin
            evs  = (ev_wdog ? 4 : 0) + (ev_alarm ? 2 : 0) + (ev_pfail ? 1 : 0);
            en   = (m_cfg >> 5) & 7;
            trig = ((evs & en) != 0);
            m_flags = flags_rd ? evs : (m_flags | evs);
            if (cfg_we) begin
                m_cfg = cfg_wdata & 8'hEC;
                m_lvl = 0;
                m_cnt = 0;
            end else if ((m_cfg & 4) != 0) begin
                if (trig) m_cnt = PT;
                else if (tick && m_cnt > 0) m_cnt = m_cnt - 1;
            end else begin
                if (trig) m_lvl = 1;
                else if (flags_rd) m_lvl = 0;
            end
        end
    end

    // compare every clock, away from the rising edge
    always @(negedge clk) begin
        bit act;
        bit e_lvl;
        bit e_pl;
        act   = ((m_cfg & 4) != 0) ? (m_cnt > 0) : (m_lvl != 0);
        e_lvl = act && ((m_cfg & 8) != 0);
        e_pl  = act && ((m_cfg & 8) == 0);
        checks++;
        if (cfg_rdata !== 8'(m_cfg) || flags !== 3'(m_flags) ||
            irq_level !== e_lvl || irq_pull_low !== e_pl) begin
            errors++;
            $display("FAIL %s t=%0t actual cfg=%h flags=%b lvl=%b pl=%b expected cfg=%h flags=%b lvl=%b pl=%b",
                     cur_req, $time, cfg_rdata, flags, irq_level, irq_pull_low,
                     8'(m_cfg), 3'(m_flags), e_lvl, e_pl);
        end
    end

    task automatic step(input bit we, input logic [7:0] wd, input bit rd,
                        input logic [2:0] ev, input bit tk);
        cfg_we = we; cfg_wdata = wd; flags_rd = rd;
        ev_wdog = ev[2]; ev_alarm = ev[1]; ev_pfail = ev[0]; tick = tk;
        @(posedge clk); #1;
        cfg_we = 1'b0; flags_rd = 1'b0;
        ev_wdog = 1'b0; ev_alarm = 1'b0; ev_pfail = 1'b0; tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 3'b000, 0);
    endtask

    task automatic wr(input logic [7:0] v);
        step(1, v, 0, 3'b000, 0);
    endtask

    task automatic direct(input bit cond, input string msg);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual cfg=%h flags=%b lvl=%b pl=%b", msg,
                     cfg_rdata, flags, irq_level, irq_pull_low);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        direct(cfg_rdata == 8'h00 && flags == 3'b000 && !irq_level && !irq_pull_low,
               "R1 reset (expected all zero)");
        rst_n = 1'b1;
        idle(2);

        // R2: writable mask, reserved bits read 0
        cur_req = "R2";
        wr(8'hFF);
        direct(cfg_rdata == 8'hEC, "R2 readback (expected ec)");
        wr(8'h13);
        direct(cfg_rdata == 8'h00, "R2 reserved only (expected 00)");

        // R3 / R5: events with all enables off set flags only
        cur_req = "R3";
        step(0, 0, 0, 3'b100, 0);
        step(0, 0, 0, 3'b010, 0);
        step(0, 0, 0, 3'b001, 0);
        idle(3);
        direct(flags == 3'b111 && !irq_level && !irq_pull_low, "R3 R5 flags set, line idle (expected 111)");

        // R4: read clears; coincident event keeps its flag
        cur_req = "R4";
        step(0, 0, 1, 3'b000, 0);
        direct(flags == 3'b000, "R4 cleared (expected 000)");
        step(0, 0, 0, 3'b101, 0);
        step(0, 0, 1, 3'b010, 0);
        direct(flags == 3'b010, "R4 read with alarm (expected 010)");
        step(0, 0, 1, 3'b000, 0);

        // R5: only the enabled source reaches the line (alarm only, push-pull, level)
        cur_req = "R5";
        wr(8'h48);
        step(0, 0, 0, 3'b101, 0);
        idle(2);
        direct(!irq_level, "R5 disabled sources (expected line 0)");
        step(0, 0, 0, 3'b010, 0);
        direct(irq_level, "R5 alarm enabled (expected line 1)");

        // R7: level hold until read; read with enabled event keeps it
        cur_req = "R7";
        idle(10);
        direct(irq_level, "R7 held (expected 1)");
        step(0, 0, 1, 3'b010, 0);
        direct(irq_level, "R7 read with event (expected 1)");
        step(0, 0, 1, 3'b000, 0);
        direct(!irq_level, "R7 released (expected 0)");

        // R6: open-drain active-low presentation
        cur_req = "R6";
        wr(8'hE0);
        step(0, 0, 0, 3'b001, 0);
        direct(irq_pull_low && !irq_level, "R6 open drain (expected pl=1 lvl=0)");
        idle(3);
        step(0, 0, 1, 3'b000, 0);

        // R8: pulse mode timed by ticks; tick in trigger cycle not counted; read ignored
        cur_req = "R8";
        wr(8'hEC);
        step(0, 0, 0, 3'b100, 1);
        for (int k = 0; k < PT - 1; k++) begin
            idle(2);
            step(0, 0, (k == 2), 3'b000, 1);
        end
        direct(irq_level, "R8 before last tick (expected 1)");
        step(0, 0, 0, 3'b000, 1);
        direct(!irq_level, "R8 after last tick (expected 0)");

        // R9: restart during a pulse
        cur_req = "R9";
        step(0, 0, 0, 3'b010, 0);
        for (int k = 0; k < PT - 2; k++) step(0, 0, 0, 3'b000, 1);
        step(0, 0, 0, 3'b001, 1);
        for (int k = 0; k < PT - 1; k++) step(0, 0, 0, 3'b000, 1);
        direct(irq_level, "R9 restarted (expected 1)");
        step(0, 0, 0, 3'b000, 1);
        direct(!irq_level, "R9 ended (expected 0)");

        // R10: write releases line; events in write cycle set flags only
        cur_req = "R10";
        step(0, 0, 1, 3'b100, 0);
        direct(irq_level, "R10 pulse armed (expected 1)");
        step(1, 8'hE0, 0, 3'b010, 0);
        direct(!irq_pull_low && !irq_level && flags[1], "R10 write release (expected line 0, alarm flag 1)");

        // mixed random stress, model compared every cycle
        cur_req = "R5";
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] w;
            w = 8'($urandom);
            step(($urandom % 40) == 0, w, ($urandom % 9) == 0,
                 3'($urandom) & {($urandom % 6) == 0, ($urandom % 5) == 0, ($urandom % 7) == 0},
                 ($urandom % 3) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule